// File: doc/BRIEF.md
# Sleep State Wake-Up Controller

This block looks after a processor core's low-power sleep state. A one-cycle sleep strobe from the core puts the controller to sleep. While it sleeps it tells the bus interface to float the data bus, and it watches three kinds of wake event. These are the core reset pin, a non-maskable interrupt, and a vector of maskable requests. Some of those requests come from external pins and some come from on-chip units such as serial channels and timers.

Each maskable request is qualified by its own enable bit. Only the non-maskable interrupt and a long enough reset pulse bypass the enables. On wake-up the controller raises a one-cycle strobe together with a 2-bit action code and a source index. The core uses them to run its reset sequence from address zero, to take an interrupt response, or to continue at the instruction after the sleep instruction. The third case happens when an enabled request arrives while the global interrupt flag is clear, which gives a fast way to line up with an external event. External pins pass through two-flop synchronisers first. The reset pin is also filtered, so short glitches do not wake the core.

Top module: `sleep_wake_ctrl`

## Requirements
- R1: When `sleep_req` is high in the awake state, `asleep` is 1 from the next cycle on. A further `sleep_req` while asleep has no visible effect.
- R2: `bus_hiz` is 1 in exactly those cycles in which `asleep` is 1.
- R3: While asleep, `core_rst_n` held low for 6 consecutive cycles wakes the core with action 2'b01 and source 0. A shorter low pulse, or two low stretches split by a high cycle that each fall short of 6, leaves the block asleep.
- R4: A high `nmi_req` while asleep always wakes the core with action 2'b10 and source 0, whatever `irq_en` and `gie` are.
- R5: A maskable request whose `irq_en` bit is 0 is ignored, and the block stays asleep.
- R6: An enabled request with `gie`=1 wakes the core with action 2'b11 (interrupt response). The source index is `ext_irq[i]` -> i and `int_irq[j]` -> 3+j.
- R7: An enabled request with `gie`=0 wakes the core with action 2'b00 (resume at the next instruction) and the same source index.
- R8: Priority among simultaneous wake events is reset, then the non-maskable interrupt, then the lowest-indexed enabled maskable request.
- R9: `wake_stb` lasts exactly one cycle, and the block is awake in the cycle after it. Outside the strobe, `wake_act` and `wake_src` are 0.
- R10: `ext_irq`, `nmi_req` and `core_rst_n` pass through a two-flop synchroniser; `int_irq` does not. So `wake_stb` rises 1 clock after an `int_irq` request, 3 clocks after an external or non-maskable request, and 8 clocks after the first low sample of the reset pin.
- R11: In the awake state, wake inputs have no effect: neither `wake_stb` nor `asleep` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| sleep_req | input | 1 | One-cycle sleep instruction strobe from the core |
| core_rst_n | input | 1 | Core reset pin, active low, asynchronous |
| nmi_req | input | 1 | Non-maskable interrupt request, asynchronous |
| ext_irq | input | 3 | External maskable interrupt pins, asynchronous |
| int_irq | input | 3 | On-chip maskable interrupt requests, synchronous |
| irq_en | input | 6 | Per-source enables, external sources in bits 2:0 |
| gie | input | 1 | Global interrupt enable flag |
| asleep | output | 1 | Controller is in the sleep state |
| bus_hiz | output | 1 | Data bus high-impedance control |
| wake_stb | output | 1 | One-cycle wake-up strobe |
| wake_act | output | 2 | 00 resume, 01 reset, 10 NMI, 11 interrupt |
| wake_src | output | 3 | Index of the maskable source that woke the core |

## Verification
A maskable on-chip request is due on the strobe one clock after it is driven. External and non-maskable requests are due three clocks after they are driven, and a held-low reset pin is due eight clocks after its first low sample. The bench drives inputs on the falling edge and counts falling edges until it sees the strobe. It compares that count with the expected latency, so an extra or missing register stage is caught. The short-pulse, split-pulse and masked cases are given a window longer than the longest latency, and the bench then confirms the block is still asleep. The reset-versus-NMI tie is timed so that both reach the decision logic on the same edge.

// File: rtl/swc_pkg.sv
package swc_pkg;

  typedef enum logic [1:0] {
    ST_AWAKE  = 2'b00,
    ST_ASLEEP = 2'b01,
    ST_WAKE   = 2'b10
  } swc_state_e;

  typedef enum logic [1:0] {
    ACT_RESUME = 2'b00,
    ACT_RESET  = 2'b01,
    ACT_NMI    = 2'b10,
    ACT_IRQ    = 2'b11
  } swc_act_e;

endpackage

// File: rtl/swc_sync.sv
module swc_sync #(
  parameter int          WIDTH   = 1,
  parameter logic [31:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_async,
  output logic [WIDTH-1:0] q_sync
);

  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  // One two-flop chain per bit, each with its own reset level.
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q[b] <= RST_VAL[b];
        stab_q[b] <= RST_VAL[b];
      end else begin
        meta_q[b] <= d_async[b];
        stab_q[b] <= meta_q[b];
      end
    end
  end

  assign q_sync = stab_q;

endmodule

// File: rtl/swc_rst_filter.sv
module swc_rst_filter #(
  parameter int HOLD = 6,
  localparam int CW  = $clog2(HOLD + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic pin_low,
  output logic fire
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          at_limit;

  assign at_limit = (cnt_q == CW'(HOLD - 1));

  always_comb begin
    cnt_d = cnt_q;
    if (!arm || !pin_low) begin
      cnt_d = '0;
    end else if (!at_limit) begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign fire = arm && pin_low && at_limit;

  AST_FIRE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(pin_low)) else $error("reset fired without prior low"); // R3

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CW'(HOLD)) else $error("reset counter overran"); // R3

endmodule

// File: rtl/swc_wake_arb.sv
module swc_wake_arb #(
  parameter int NSRC = 6,
  localparam int SW  = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic [NSRC-1:0] req,
  input  logic [NSRC-1:0] en,
  output logic            hit,
  output logic [SW-1:0]   idx
);

  logic [NSRC-1:0] live;

  assign live = req & en;
  assign hit  = |live;

  // Scan from the top down so the lowest live index is written last.
  always_comb begin
    idx = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (live[i]) begin
        idx = SW'(i);
      end
    end
  end

  always_comb begin
    if (hit) begin
      AST_IDX_PENDING: assert (req[idx] && en[idx]) else $error("picked idle source"); // R8
    end
  end

endmodule

// File: rtl/sleep_wake_ctrl.sv
module sleep_wake_ctrl
  import swc_pkg::*;
#(
  parameter int NEXT     = 3,
  parameter int NINT     = 3,
  parameter int RST_HOLD = 6,
  localparam int NSRC    = NEXT + NINT,
  localparam int SW      = (NSRC > 1) ? $clog2(NSRC) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sleep_req,
  input  logic            core_rst_n,
  input  logic            nmi_req,
  input  logic [NEXT-1:0] ext_irq,
  input  logic [NINT-1:0] int_irq,
  input  logic [NSRC-1:0] irq_en,
  input  logic            gie,
  output logic            asleep,
  output logic            bus_hiz,
  output logic            wake_stb,
  output logic [1:0]      wake_act,
  output logic [SW-1:0]   wake_src
);

  // Synchronised external inputs: NMI on top, maskable pins below.
  logic [NEXT:0]   pins_s;
  logic [0:0]      rstpin_s;
  logic            nmi_s;
  logic [NEXT-1:0] ext_s;
  logic [NSRC-1:0] req_all;

  swc_sync #(.WIDTH(NEXT + 1), .RST_VAL('0)) u_sync_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async({nmi_req, ext_irq}),
    .q_sync (pins_s)
  );

  swc_sync #(.WIDTH(1), .RST_VAL(32'd1)) u_sync_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_async(core_rst_n),
    .q_sync (rstpin_s)
  );

  assign nmi_s   = pins_s[NEXT];
  assign ext_s   = pins_s[NEXT-1:0];
  assign req_all = {int_irq, ext_s};

  swc_state_e state_q, state_d;
  logic       rst_fire;
  logic       hit;
  logic [SW-1:0] pick;

  swc_rst_filter #(.HOLD(RST_HOLD)) u_rst_filt (
    .clk    (clk),
    .rst_n  (rst_n),
    .arm    (state_q == ST_ASLEEP),
    .pin_low(!rstpin_s[0]),
    .fire   (rst_fire)
  );

  swc_wake_arb #(.NSRC(NSRC)) u_arb (
    .req(req_all),
    .en (irq_en),
    .hit(hit),
    .idx(pick)
  );

  // Wake decision in fixed priority order.
  logic       go;
  swc_act_e   act_c;
  logic [SW-1:0] src_c;

  always_comb begin
    go    = 1'b0;
    act_c = ACT_RESUME;
    src_c = '0;
    if (rst_fire) begin
      go    = 1'b1;
      act_c = ACT_RESET;
    end else if (nmi_s) begin
      go    = 1'b1;
      act_c = ACT_NMI;
    end else if (hit) begin
      go    = 1'b1;
      act_c = gie ? ACT_IRQ : ACT_RESUME;
      src_c = pick;
    end
  end

  // Next-state logic.
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_AWAKE:  if (sleep_req) state_d = ST_ASLEEP;
      ST_ASLEEP: if (go)        state_d = ST_WAKE;
      ST_WAKE:                  state_d = ST_AWAKE;
      default:                  state_d = ST_AWAKE;
    endcase
  end

  logic          load_en;
  swc_act_e      act_q, act_d;
  logic [SW-1:0] src_q, src_d;
  logic          hiz_q, hiz_d;

  assign load_en = (state_q == ST_ASLEEP) && go;

  always_comb begin
    act_d = load_en ? act_c : ACT_RESUME;
    src_d = load_en ? src_c : '0;
    hiz_d = (state_d == ST_ASLEEP);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_AWAKE;
      act_q   <= ACT_RESUME;
      src_q   <= '0;
      hiz_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      act_q   <= act_d;
      src_q   <= src_d;
      hiz_q   <= hiz_d;
    end
  end

  assign asleep   = (state_q == ST_ASLEEP);
  assign bus_hiz  = hiz_q;
  assign wake_stb = (state_q == ST_WAKE);
  assign wake_act = act_q;
  assign wake_src = src_q;

  AST_SLEEP_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AWAKE && sleep_req) |=> asleep) else $error("no sleep entry"); // R1

  AST_HIZ_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    bus_hiz == asleep) else $error("bus float mismatch"); // R2

  AST_NMI_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASLEEP && nmi_s && !rst_fire) |=> (wake_stb && wake_act == ACT_NMI))
    else $error("nmi did not wake"); // R4

  AST_MASKED_STAY: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASLEEP && !rst_fire && !nmi_s && ((req_all & irq_en) == '0)) |=> asleep)
    else $error("left sleep without cause"); // R5

  AST_GIE_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ASLEEP && !rst_fire && !nmi_s && hit && !gie) |=> (wake_stb && wake_act == ACT_RESUME))
    else $error("expected resume action"); // R7

  AST_STB_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    wake_stb |=> (!wake_stb && !asleep)) else $error("strobe too long"); // R9

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !wake_stb |-> (wake_act == 2'b00 && wake_src == '0)) else $error("stale action"); // R9

  AST_AWAKE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_AWAKE && !sleep_req) |=> (!asleep && !wake_stb)) else $error("awake woke"); // R11

endmodule

// File: tb/sleep_wake_ctrl_bench.sv
module sleep_wake_ctrl_bench;

  localparam int CLK_PERIOD = 10;
  localparam int NV = 8;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sleep_req;
  logic       core_rst_n;
  logic       nmi_req;
  logic [2:0] ext_irq;
  logic [2:0] int_irq;
  logic [5:0] irq_en;
  logic       gie;
  logic       asleep, bus_hiz, wake_stb;
  logic [1:0] wake_act;
  logic [2:0] wake_src;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  sleep_wake_ctrl u_sleep_wake_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .sleep_req (sleep_req),
    .core_rst_n(core_rst_n),
    .nmi_req   (nmi_req),
    .ext_irq   (ext_irq),
    .int_irq   (int_irq),
    .irq_en    (irq_en),
    .gie       (gie),
    .asleep    (asleep),
    .bus_hiz   (bus_hiz),
    .wake_stb  (wake_stb),
    .wake_act  (wake_act),
    .wake_src  (wake_src)
  );

  // Fields: ext[21:19] int[18:16] en[15:10] gie[9] wake[8] act[7:6] src[5:3] lat[2:0]
  localparam logic [21:0] VEC [NV] = '{
    {3'b001, 3'b000, 6'b000001, 1'b1, 1'b1, 2'b11, 3'd0, 3'd3},
    {3'b100, 3'b000, 6'b000100, 1'b1, 1'b1, 2'b11, 3'd2, 3'd3},
    {3'b000, 3'b010, 6'b010000, 1'b0, 1'b1, 2'b00, 3'd4, 3'd1},
    {3'b000, 3'b100, 6'b100000, 1'b1, 1'b1, 2'b11, 3'd5, 3'd1},
    {3'b010, 3'b000, 6'b000010, 1'b0, 1'b1, 2'b00, 3'd1, 3'd3},
    {3'b001, 3'b001, 6'b110110, 1'b1, 1'b0, 2'b00, 3'd0, 3'd0},
    {3'b000, 3'b011, 6'b111111, 1'b1, 1'b1, 2'b11, 3'd3, 3'd1},
    {3'b110, 3'b000, 6'b111111, 1'b1, 1'b1, 2'b11, 3'd1, 3'd3}
  };

  task automatic chk(input string req, input int actual, input int expected);
    checks++;
    if (actual !== expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic clear_stim();
    ext_irq    = '0;
    int_irq    = '0;
    nmi_req    = 1'b0;
    core_rst_n = 1'b1;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic go_sleep();
    idle(3);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    chk("R1 asleep", int'(asleep), 1);
    chk("R2 bus_hiz", int'(bus_hiz), 1);
  endtask

  // Polls falling edges; lat is the edge count at which the strobe shows, 0 if never.
  task automatic wait_wake(input int maxc, input int rel_at, output int lat,
                           output logic [1:0] a, output logic [2:0] s);
    lat = 0;
    a   = '0;
    s   = '0;
    for (int c = 1; c <= maxc; c++) begin
      @(negedge clk);
      if (wake_stb) begin
        lat = c;
        a   = wake_act;
        s   = wake_src;
        clear_stim();
        break;
      end
      if (c == rel_at) clear_stim();
    end
    if (lat != 0) begin
      @(negedge clk);
      chk("R9 strobe single", int'(wake_stb), 0);
      chk("R9 awake after", int'(asleep), 0);
      chk("R2 bus released", int'(bus_hiz), 0);
      chk("R9 act idle", int'(wake_act), 0);
    end
  endtask

  task automatic wake_by_int();
    int lat;
    logic [1:0] a;
    logic [2:0] s;
    irq_en  = 6'b111111;
    gie     = 1'b1;
    int_irq = 3'b001;
    wait_wake(4, 0, lat, a, s);
    chk("R10 internal latency", lat, 1);
    chk("R6 int src", int'(s), 3);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int lat;
    logic [1:0] a;
    logic [2:0] s;

    rst_n     = 1'b0;
    sleep_req = 1'b0;
    irq_en    = '0;
    gie       = 1'b0;
    clear_stim();
    idle(3);
    rst_n = 1'b1;
    idle(1);

    chk("R9 reset stb", int'(wake_stb), 0);
    chk("R1 reset asleep", int'(asleep), 0);
    chk("R2 reset hiz", int'(bus_hiz), 0);
    chk("R9 reset act", int'(wake_act), 0);
    chk("R9 reset src", int'(wake_src), 0);

    // R11: wake sources while awake
    irq_en  = 6'b111111;
    gie     = 1'b1;
    int_irq = 3'b111;
    ext_irq = 3'b111;
    nmi_req = 1'b1;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R11 no strobe awake", int'(wake_stb), 0);
    end
    chk("R11 still awake", int'(asleep), 0);
    clear_stim();

    // Vector table
    for (int v = 0; v < NV; v++) begin
      go_sleep();
      irq_en  = VEC[v][15:10];
      gie     = VEC[v][9];
      ext_irq = VEC[v][21:19];
      int_irq = VEC[v][18:16];
      wait_wake(6, 0, lat, a, s);
      if (VEC[v][8]) begin
        chk($sformatf("R10 latency v%0d", v), lat, int'(VEC[v][2:0]));
        chk($sformatf("R6 R7 action v%0d", v), int'(a), int'(VEC[v][7:6]));
        chk($sformatf("R8 source v%0d", v), int'(s), int'(VEC[v][5:3]));
      end else begin
        chk($sformatf("R5 masked no wake v%0d", v), lat, 0);
        chk("R5 still asleep", int'(asleep), 1);
        clear_stim();
        // R4: NMI wakes despite enables off
        irq_en  = '0;
        gie     = 1'b0;
        nmi_req = 1'b1;
        wait_wake(6, 0, lat, a, s);
        chk("R4 nmi latency", lat, 3);
        chk("R4 nmi action", int'(a), 2);
        chk("R4 nmi src", int'(s), 0);
      end
    end

    // R3: 5-cycle low pulse is ignored; R1 repeated strobe ignored
    go_sleep();
    irq_en     = '0;
    core_rst_n = 1'b0;
    wait_wake(12, 5, lat, a, s);
    chk("R3 short pulse", lat, 0);
    chk("R3 still asleep", int'(asleep), 1);
    sleep_req = 1'b1;
    @(negedge clk);
    sleep_req = 1'b0;
    @(negedge clk);
    chk("R1 strobe while asleep", int'(asleep), 1);
    chk("R1 no wake on strobe", int'(wake_stb), 0);
    wake_by_int();

    // R3: split low stretches 4 + 4 with one high cycle between
    go_sleep();
    irq_en     = '0;
    core_rst_n = 1'b0;
    idle(4);
    core_rst_n = 1'b1;
    idle(1);
    core_rst_n = 1'b0;
    idle(4);
    core_rst_n = 1'b1;
    wait_wake(8, 0, lat, a, s);
    chk("R3 split pulse", lat, 0);
    chk("R3 split asleep", int'(asleep), 1);
    wake_by_int();

    // R3: exactly 6 low cycles wakes with reset action
    go_sleep();
    irq_en     = 6'b111111;
    gie        = 1'b1;
    core_rst_n = 1'b0;
    wait_wake(12, 6, lat, a, s);
    chk("R3 R10 reset latency", lat, 8);
    chk("R3 reset action", int'(a), 1);
    chk("R3 reset src", int'(s), 0);

    // R8: reset completes on the same edge NMI arrives
    go_sleep();
    core_rst_n = 1'b0;
    for (int c = 0; c < 5; c++) begin
      @(negedge clk);
      chk("R8 no early wake", int'(wake_stb), 0);
    end
    nmi_req = 1'b1;
    ext_irq = 3'b001;
    wait_wake(6, 0, lat, a, s);
    chk("R8 tie latency", lat, 3);
    chk("R8 reset beats nmi", int'(a), 1);

    idle(2);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule